// File: doc/BRIEF.md
# E1 Transmit Overhead Formatter

This block builds the outgoing E1 bit stream from a serial payload input. Each frame has 32 timeslots of 8 bits. Alignment frames and non-alignment frames alternate. The block writes the timeslot-0 overhead, which is either the frame alignment word or the international, alarm and national bits. In channel-associated signaling mode it also writes the timeslot-16 multiframe word of frame 0. After that it applies the per-timeslot idle-code overrides and the all-ones overrides.

Position is kept by bit, slot and frame counters that run freely. A rising edge on the frame-sync input or the multiframe-sync input moves them. Each edge arrives one clock before the boundary it marks. The serial output follows the input by one clock. Two markers come out in step with the output bits. One is high during alignment frames and the other is high during frame 0 of the 16-frame multiframe.

Top module: `e1tx_fmt`

## Requirements
- R1: While `rstN` is low, `txOut`, `alignMark` and `mfMark` are 0. The first cycle after release is timeslot 0, bit 1, of frame 0.
- R2: A frame is 256 bit times: 32 slots of 8 bits, with bit 1 sent first. An input bit in a position without overhead or override appears unchanged at `txOut` one clock after it is sampled.
- R3: When `alignOdd`=0, the even frames of the multiframe are alignment frames. When `alignOdd`=1, the odd frames are. In alignment frames, bits 2..8 of timeslot 0 are 0,0,1,1,0,1,1. `alignMark` is high, and `mfMark` is high in frame 0, both aligned with the output bits.
- R4: Bit 1 of timeslot 0 in every frame is `intlBit` when `intlFromReg`=1. Otherwise it is the serial input bit.
- R5: In non-alignment frames, timeslot 0 carries: bit 2 = 1, bit 3 = `remAlarm`, and bits 4..8 = `natBits[4]`..`natBits[0]` when `natFromReg`=1. When `natFromReg`=0, bits 4..8 are the serial input bits.
- R6: With `casMode`=1, timeslot 16 of frame 0 carries 0,0,0,0, then `extraBits[2]`, `mfAlarm`, `extraBits[1]` and `extraBits[0]`. With `casMode`=0, timeslot 16 passes the serial input.
- R7: `idleMask[n]`=1 replaces slot n, overhead included, with 1,1,0,1,0,1,0,1 (bit 1 first).
- R8: `sigOnes`=1 forces timeslot 16 of every frame to ones. This takes priority over the idle code.
- R9: `allOnes`=1 forces every output bit to 1 and takes priority over everything else. The markers are unaffected.
- R10: A rising edge on `frameSync` makes the next cycle timeslot 0, bit 1, of the following frame (frame index +1, mod 16). Holding the input high does not realign again.
- R11: A rising edge on `mfSync` makes the next cycle timeslot 0, bit 1, of frame 0. This wins over a simultaneous `frameSync` edge.
- R12: With both sync inputs low, the block keeps 256-cycle frames and 16-frame multiframes on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| serIn | input | 1 | Serial payload bit |
| frameSync | input | 1 | Frame position sync, rising edge one clock early |
| mfSync | input | 1 | Multiframe position sync, rising edge one clock early |
| alignOdd | input | 1 | 1 makes odd frames the alignment frames |
| intlFromReg | input | 1 | International bit from `intlBit` rather than input |
| intlBit | input | 1 | Register value of the international bit |
| natFromReg | input | 1 | National bits from `natBits` rather than input |
| natBits | input | 5 | National bits, bit 4 sent first |
| remAlarm | input | 1 | Remote alarm bit |
| casMode | input | 1 | 1 = channel-associated signaling layout in slot 16 |
| extraBits | input | 3 | Extra bits of slot 16, frame 0 |
| mfAlarm | input | 1 | Distant multiframe alarm bit |
| idleMask | input | 32 | Per-slot idle code enables |
| sigOnes | input | 1 | Force slot 16 to ones |
| allOnes | input | 1 | Force the whole stream to ones |
| txOut | output | 1 | Formatted NRZ bit stream |
| alignMark | output | 1 | High during alignment frames |
| mfMark | output | 1 | High during multiframe frame 0 |

## Verification
The hardest case to reach is a sync edge that lands mid-frame, together with a sync input held high for several cycles. Under free-running stimulus neither appears, so the bench drives both on purpose. It pulses the frame sync at an arbitrary bit position and holds it high for three cycles. It also raises both sync inputs in the same cycle. A bench-side position model then predicts every following bit across whole multiframes. Between these directed phases, short segments with random configuration mix overrides, signaling modes and alignment parity.

// File: rtl/e1tx_pkg.sv
package e1tx_pkg;
  localparam int SLOTS    = 32;
  localparam int BITS     = 8;
  localparam int FRAMES   = 16;
  localparam int NAT_N    = 5;
  localparam int XB_N     = 3;
  localparam int SIG_SLOT = 16;
  localparam int BIT_W    = $clog2(BITS);
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int FRM_W    = $clog2(FRAMES);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(BITS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
  localparam logic [FRM_W-1:0]  FRM_LAST  = FRM_W'(FRAMES - 1);
  // MSB is sent first
  localparam logic [BITS-1:0] IDLE_CODE = 8'b1101_0101;
  localparam logic [BITS-2:0] FAS_WORD  = 7'b001_1011;

  typedef struct packed {
    logic [BIT_W-1:0]  bitIdx;
    logic [SLOT_W-1:0] slotIdx;
    logic [FRM_W-1:0]  frameIdx;
    logic              alignFrm;
    logic              mfFrm;
  } posStrb_t;
endpackage

// File: rtl/e1tx_ctrl.sv
module e1tx_ctrl
  import e1tx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameSync,
  input  logic     mfSync,
  input  logic     alignOdd,
  output posStrb_t strb
);
  logic fsPrev, msPrev;
  logic fsRise, msRise;
  logic [BIT_W-1:0]  bitQ;
  logic [SLOT_W-1:0] slotQ;
  logic [FRM_W-1:0]  frmQ;
  logic [FRM_W-1:0]  frmNext;

  assign fsRise  = frameSync & ~fsPrev;
  assign msRise  = mfSync & ~msPrev;
  assign frmNext = (frmQ == FRM_LAST) ? '0 : frmQ + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsPrev <= 1'b0;
      msPrev <= 1'b0;
      bitQ   <= '0;
      slotQ  <= '0;
      frmQ   <= '0;
    end else begin
      fsPrev <= frameSync;
      msPrev <= mfSync;
      if (msRise) begin
        bitQ  <= '0;
        slotQ <= '0;
        frmQ  <= '0;
      end else if (fsRise) begin
        bitQ  <= '0;
        slotQ <= '0;
        frmQ  <= frmNext;
      end else if (bitQ == BIT_LAST) begin
        bitQ <= '0;
        if (slotQ == SLOT_LAST) begin
          slotQ <= '0;
          frmQ  <= frmNext;
        end else begin
          slotQ <= slotQ + 1'b1;
        end
      end else begin
        bitQ <= bitQ + 1'b1;
      end
    end
  end

  always_comb begin
    strb.bitIdx   = bitQ;
    strb.slotIdx  = slotQ;
    strb.frameIdx = frmQ;
    strb.alignFrm = ~(frmQ[0] ^ alignOdd);
    strb.mfFrm    = (frmQ == '0);
  end
endmodule

// File: rtl/e1tx_dpath.sv
module e1tx_dpath
  import e1tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  posStrb_t          strb,
  input  logic              serIn,
  input  logic              intlFromReg,
  input  logic              intlBit,
  input  logic              natFromReg,
  input  logic [NAT_N-1:0]  natBits,
  input  logic              remAlarm,
  input  logic              casMode,
  input  logic [XB_N-1:0]   extraBits,
  input  logic              mfAlarm,
  input  logic [SLOTS-1:0]  idleMask,
  input  logic              sigOnes,
  input  logic              allOnes,
  output logic              txOut,
  output logic              alignMark,
  output logic              mfMark
);
  logic [BIT_W-1:0] revIdx;
  logic inSlot0, inSig, nextBit;

  assign revIdx  = BIT_LAST - strb.bitIdx;
  assign inSlot0 = (strb.slotIdx == '0);
  assign inSig   = (strb.slotIdx == SLOT_W'(SIG_SLOT));

  always_comb begin
    nextBit = serIn;
    if (inSlot0) begin
      if (strb.bitIdx == '0)
        nextBit = intlFromReg ? intlBit : serIn;
      else if (strb.alignFrm)
        nextBit = FAS_WORD[revIdx];
      else if (strb.bitIdx == BIT_W'(1))
        nextBit = 1'b1;
      else if (strb.bitIdx == BIT_W'(2))
        nextBit = remAlarm;
      else
        nextBit = natFromReg ? natBits[revIdx] : serIn;
    end else if (inSig && casMode && strb.mfFrm) begin
      case (strb.bitIdx)
        BIT_W'(4): nextBit = extraBits[2];
        BIT_W'(5): nextBit = mfAlarm;
        BIT_W'(6): nextBit = extraBits[1];
        BIT_W'(7): nextBit = extraBits[0];
        default:   nextBit = 1'b0;
      endcase
    end
    if (idleMask[strb.slotIdx]) nextBit = IDLE_CODE[revIdx];
    if (sigOnes && inSig)       nextBit = 1'b1;
    if (allOnes)                nextBit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txOut     <= 1'b0;
      alignMark <= 1'b0;
      mfMark    <= 1'b0;
    end else begin
      txOut     <= nextBit;
      alignMark <= strb.alignFrm;
      mfMark    <= strb.mfFrm;
    end
  end
endmodule

// File: rtl/e1tx_fmt.sv
module e1tx_fmt
  import e1tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              frameSync,
  input  logic              mfSync,
  input  logic              alignOdd,
  input  logic              intlFromReg,
  input  logic              intlBit,
  input  logic              natFromReg,
  input  logic [NAT_N-1:0]  natBits,
  input  logic              remAlarm,
  input  logic              casMode,
  input  logic [XB_N-1:0]   extraBits,
  input  logic              mfAlarm,
  input  logic [SLOTS-1:0]  idleMask,
  input  logic              sigOnes,
  input  logic              allOnes,
  output logic              txOut,
  output logic              alignMark,
  output logic              mfMark
);
  posStrb_t strb;

  e1tx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .mfSync(mfSync),
    .alignOdd(alignOdd), .strb(strb)
  );

  e1tx_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .serIn(serIn),
    .intlFromReg(intlFromReg), .intlBit(intlBit),
    .natFromReg(natFromReg), .natBits(natBits), .remAlarm(remAlarm),
    .casMode(casMode), .extraBits(extraBits), .mfAlarm(mfAlarm),
    .idleMask(idleMask), .sigOnes(sigOnes), .allOnes(allOnes),
    .txOut(txOut), .alignMark(alignMark), .mfMark(mfMark)
  );
endmodule

// File: rtl/e1tx_fmt_chk.sv
module e1tx_fmt_chk
  import e1tx_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             frameSync,
  input logic             mfSync,
  input logic             alignOdd,
  input logic [SLOTS-1:0] idleMask,
  input logic             sigOnes,
  input logic             allOnes,
  input logic             txOut,
  input logic             alignMark,
  input logic             mfMark,
  input posStrb_t         strb
);
  logic [BIT_W-1:0] rev;
  logic sigHere;
  assign rev     = BIT_LAST - strb.bitIdx;
  assign sigHere = sigOnes && (strb.slotIdx == SLOT_W'(SIG_SLOT));

  AST_UNFRAMED_ONES: assert property (@(posedge clk) disable iff (!rstN)
    allOnes |=> txOut); // R9
  AST_SIG_SLOT_ONES: assert property (@(posedge clk) disable iff (!rstN)
    sigHere |=> txOut); // R8
  AST_IDLE_PATTERN: assert property (@(posedge clk) disable iff (!rstN)
    (idleMask[strb.slotIdx] && !allOnes && !sigHere) |=> (txOut == $past(IDLE_CODE[rev]))); // R7
  AST_FSYNC_REALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && !$past(frameSync)) |=> (strb.bitIdx == '0 && strb.slotIdx == '0)); // R10
  AST_MFSYNC_FRAME0: assert property (@(posedge clk) disable iff (!rstN)
    (mfSync && !$past(mfSync)) |=> (strb.frameIdx == '0 && strb.bitIdx == '0 && strb.slotIdx == '0)); // R11
  AST_MARK_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    mfMark |-> (alignMark == !$past(alignOdd))); // R3
endmodule

bind e1tx_fmt e1tx_fmt_chk u_chk (
  .clk(clk), .rstN(rstN), .frameSync(frameSync), .mfSync(mfSync),
  .alignOdd(alignOdd), .idleMask(idleMask), .sigOnes(sigOnes),
  .allOnes(allOnes), .txOut(txOut), .alignMark(alignMark),
  .mfMark(mfMark), .strb(strb)
);

// File: tb/sim_e1tx_fmt.sv
module sim_e1tx_fmt;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0, frameSync = 1'b0, mfSync = 1'b0, alignOdd = 1'b0;
  logic intlFromReg = 1'b0, intlBit = 1'b0, natFromReg = 1'b0, remAlarm = 1'b0;
  logic [4:0] natBits = '0;
  logic casMode = 1'b0, mfAlarm = 1'b0, sigOnes = 1'b0, allOnes = 1'b0;
  logic [2:0] extraBits = '0;
  logic [31:0] idleMask = '0;
  logic txOut, alignMark, mfMark;

  int testCnt = 0, failCnt = 0;
  int mBit = 0, mSlot = 0, mFrm = 0;
  logic mFsPrev = 1'b0, mMsPrev = 1'b0;

  always #2 clk = ~clk;

  e1tx_fmt u0 (
    .clk(clk), .rstN(rstN), .serIn(serIn), .frameSync(frameSync), .mfSync(mfSync),
    .alignOdd(alignOdd), .intlFromReg(intlFromReg), .intlBit(intlBit),
    .natFromReg(natFromReg), .natBits(natBits), .remAlarm(remAlarm),
    .casMode(casMode), .extraBits(extraBits), .mfAlarm(mfAlarm),
    .idleMask(idleMask), .sigOnes(sigOnes), .allOnes(allOnes),
    .txOut(txOut), .alignMark(alignMark), .mfMark(mfMark)
  );

  function automatic logic isAlign(int f);
    return (f % 2) == int'(alignOdd);
  endfunction

  function automatic logic expBit(logic ser, int b, int s, int f);
    logic [7:0] idle = 8'b1101_0101;
    logic [6:0] fas  = 7'b001_1011;
    logic v = ser;
    if (s == 0) begin
      if (b == 0) v = intlFromReg ? intlBit : ser;
      else if (isAlign(f)) v = fas[7 - b];
      else if (b == 1) v = 1'b1;
      else if (b == 2) v = remAlarm;
      else v = natFromReg ? natBits[7 - b] : ser;
    end else if (s == 16 && casMode && f == 0) begin
      case (b)
        4: v = extraBits[2];
        5: v = mfAlarm;
        6: v = extraBits[1];
        7: v = extraBits[0];
        default: v = 1'b0;
      endcase
    end
    if (idleMask[s]) v = idle[7 - b];
    if (sigOnes && s == 16) v = 1'b1;
    if (allOnes) v = 1'b1;
    return v;
  endfunction

  function automatic string reqTag(int b, int s, int f);
    if (allOnes) return "R9";
    if (sigOnes && s == 16) return "R8";
    if (idleMask[s]) return "R7";
    if (s == 0 && b == 0) return "R4";
    if (s == 0) return isAlign(f) ? "R3" : "R5";
    if (s == 16 && casMode && f == 0) return "R6";
    return "R2";
  endfunction

  task automatic check(string tag, logic act, logic exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %b expected %b (slot model %0d/%0d/%0d)", tag, act, exp, mFrm, mSlot, mBit);
    end
  endtask

  // Called at a negedge: drive one bit time, then check the output one clock later.
  task automatic step(logic ser, logic fs, logic ms, string tagIn);
    logic eBit, eAl, eMf;
    string tag;
    serIn = ser; frameSync = fs; mfSync = ms;
    eBit = expBit(ser, mBit, mSlot, mFrm);
    eAl  = isAlign(mFrm);
    eMf  = (mFrm == 0);
    tag  = (tagIn != "") ? tagIn : reqTag(mBit, mSlot, mFrm);
    if (ms && !mMsPrev) begin
      mBit = 0; mSlot = 0; mFrm = 0;
    end else if (fs && !mFsPrev) begin
      mBit = 0; mSlot = 0; mFrm = (mFrm + 1) % 16;
    end else begin
      mBit++;
      if (mBit == 8) begin
        mBit = 0; mSlot++;
        if (mSlot == 32) begin mSlot = 0; mFrm = (mFrm + 1) % 16; end
      end
    end
    mFsPrev = fs; mMsPrev = ms;
    @(posedge clk); @(negedge clk);
    check(tag, txOut, eBit);
    if (alignMark !== eAl || mfMark !== eMf) begin
      testCnt++; failCnt++;
      $display("FAIL R3: markers actual %b%b expected %b%b", alignMark, mfMark, eAl, eMf);
    end
  endtask

  task automatic randCfg();
    alignOdd    = 1'($urandom % 2);
    intlFromReg = 1'($urandom % 2);
    intlBit     = 1'($urandom % 2);
    natFromReg  = 1'($urandom % 2);
    natBits     = 5'($urandom);
    remAlarm    = 1'($urandom % 2);
    casMode     = 1'($urandom % 2);
    extraBits   = 3'($urandom);
    mfAlarm     = 1'($urandom % 2);
    idleMask    = $urandom & $urandom & $urandom;
    sigOnes     = ($urandom % 4) == 0;
    allOnes     = ($urandom % 8) == 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    #800000;
    testCnt++; failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check("R1", txOut, 1'b0);
    check("R1", alignMark, 1'b0);
    check("R1", mfMark, 1'b0);
    rstN = 1'b1;
    // R1: first bit after release is slot 0 bit 1 of frame 0 (model starts at 0)
    intlFromReg = 1'b1; intlBit = 1'b1; natFromReg = 1'b1; natBits = 5'b10110;
    remAlarm = 1'b1; casMode = 1'b1; extraBits = 3'b101; mfAlarm = 1'b1;
    step(1'b0, 1'b0, 1'b0, "R1");
    for (int i = 0; i < 300; i++) step(1'($urandom % 2), 1'b0, 1'b0, "");
    // R11: multiframe sync mid-frame
    step(1'($urandom % 2), 1'b0, 1'b1, "");
    step(1'($urandom % 2), 1'b0, 1'b0, "R11");
    for (int i = 0; i < 2 * 4096; i++) step(1'($urandom % 2), 1'b0, 1'b0, "");
    // serial sources for overhead, odd alignment
    intlFromReg = 1'b0; natFromReg = 1'b0; alignOdd = 1'b1; casMode = 1'b0;
    for (int i = 0; i < 4096; i++) step(1'($urandom % 2), 1'b0, 1'b0, "");
    // R10: frame sync at an arbitrary position, held high three cycles
    for (int i = 0; i < 77; i++) step(1'($urandom % 2), 1'b0, 1'b0, "");
    step(1'b1, 1'b1, 1'b0, "");
    step(1'b0, 1'b1, 1'b0, "R10");
    step(1'b1, 1'b1, 1'b0, "R10");
    for (int i = 0; i < 600; i++) step(1'($urandom % 2), 1'b0, 1'b0, "R10");
    // R11: both sync edges together, multiframe wins
    step(1'b0, 1'b1, 1'b1, "");
    step(1'b1, 1'b0, 1'b0, "R11");
    for (int i = 0; i < 300; i++) step(1'($urandom % 2), 1'b0, 1'b0, "R11");
    // random configuration segments
    for (int seg = 0; seg < 24; seg++) begin
      randCfg();
      for (int i = 0; i < 512; i++) step(1'($urandom % 2), 1'b0, 1'b0, "");
    end
    // directed overrides: idle on slot 0 and 16 with signaling ones
    allOnes = 1'b0; sigOnes = 1'b1; idleMask = 32'h0001_0001; casMode = 1'b1;
    for (int i = 0; i < 4096; i++) step(1'($urandom % 2), 1'b0, 1'b0, "");
    sigOnes = 1'b0;
    for (int i = 0; i < 4096; i++) step(1'($urandom % 2), 1'b0, 1'b0, "");
    // R12: free-run over two multiframes with plain overhead
    idleMask = '0;
    for (int i = 0; i < 2 * 4096; i++) step(1'($urandom % 2), 1'b0, 1'b0, "R12");
    summary();
  end
endmodule